// File: doc/BRIEF.md
# Dual fractional baud tick generator

This block turns a fast reference clock into the oversampling enables that a UART transmitter and receiver run on. Each direction has its own divider, made of a 16-bit whole part and a 4-bit sixteenths part, so the two sides can run at unrelated rates. A shared prescaler first slows the reference by 1 or by 4. The fractional divider then emits one single-cycle tick per oversample period.

The fractional part is not applied by jitter at random. Over each run of sixteen periods, exactly F of them are lengthened by one prescaled cycle, and those longer periods are spread as evenly as the count allows. A shared two-bit field picks 16, 8 or 4 oversamples per bit. A second strobe per direction marks every bit boundary, so fewer samples per bit give a faster line for the same divider.

Software writes to a divisor register appear here as a restart pulse. The pulse puts that direction's counters back to a known phase, so a new rate starts with a whole period.

Top module: `baud_gen_dual`

## Requirements
- R1: While reset is held, all four outputs (both ticks and both bit strobes) stay low.
- R2: With the prescaler select high, every tick interval is four times as long as it is with the select low, for the same divisor.
- R3: With fraction 0 and integer divisor N ≥ 1, consecutive ticks of a direction are N prescaled cycles apart.
- R4: With fraction F, period k (counted from 0 at restart; the period that ends with the first tick is k = 0) lasts N+1 prescaled cycles when floor((k+1)·F/16) > floor(k·F/16), and N otherwise.
- R5: An integer divisor of 0 stops that direction's ticks entirely.
- R6: With the prescaler select low, integer divisor 1 and fraction 0, the tick is high on every cycle.
- R7: A restart pulse suppresses any tick on the edge where it is taken. It also clears the phase, so the next tick comes N prescaled cycles later.
- R8: The sampling select codes 00, 01, 10 and 11 give 16, 8, 4 and 16 ticks per bit. A bit strobe rises together with every OSR-th tick counted from restart.
- R9: The transmit and receive dividers take separate divisors and restarts, and neither one changes the other's tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_div4 | input | 1 | 1 = divide the reference by 4 first, 0 = by 1 |
| osr_sel | input | 2 | Oversampling select: 00=16X, 01=8X, 10=4X, 11=16X |
| tx_div_int | input | 16 | Transmit integer divisor |
| tx_div_frac | input | 4 | Transmit divisor in sixteenths |
| tx_div_wr | input | 1 | Transmit divisor written; restarts transmit phase |
| rx_div_int | input | 16 | Receive integer divisor |
| rx_div_frac | input | 4 | Receive divisor in sixteenths |
| rx_div_wr | input | 1 | Receive divisor written; restarts receive phase |
| tx_tick | output | 1 | Transmit oversample enable, one cycle |
| tx_bit | output | 1 | Transmit bit-boundary strobe |
| rx_tick | output | 1 | Receive oversample enable, one cycle |
| rx_bit | output | 1 | Receive bit-boundary strobe |

## Verification
Two events can fall on the same clock edge: a divisor-write restart, and the period end that would otherwise produce a tick. The bench first locks onto a 3-cycle tick train. It then times the write so that it is taken on the exact edge of the next expected tick. It checks that no tick appears there and that the new phase yields a tick three cycles later. Interval lengths are predicted from the floor-difference formula of R4. This formula is a different statement from the accumulator carry that the hardware uses.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    OSR_X16 = 2'b00,
    OSR_X8  = 2'b01,
    OSR_X4  = 2'b10,
    OSR_RSV = 2'b11
  } osr_sel_e;

  localparam int SUB_W = 5;

  // Oversamples per bit for a select code; the spare code falls back to 16.
  function automatic logic [SUB_W-1:0] osr_ticks(input logic [1:0] sel);
    case (osr_sel_e'(sel))
      OSR_X8:  osr_ticks = SUB_W'(8);
      OSR_X4:  osr_ticks = SUB_W'(4);
      default: osr_ticks = SUB_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_div,
  output logic pre_en
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign pre_en = sel_div ? (cnt == LAST) : 1'b1;

  generate
    if (RATIO > 1) begin : g_chk
      // R2: in divided mode two enables never sit on adjacent cycles
      p_pre_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_div && pre_en) |=> !(sel_div && pre_en));
    end
  endgenerate
endmodule

// File: rtl/baud_chan.sv
module baud_chan
  import baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_en,
  input  logic              restart,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic [1:0]        osr_sel,
  output logic              tick,
  output logic              bit_stb
);
  localparam int LW = DIV_W + 1;

  // Carry out of the phase accumulator marks a lengthened period.
  function automatic logic frac_carry(input logic [FRAC_W-1:0] acc,
                                      input logic [FRAC_W-1:0] frac);
    logic [FRAC_W:0] sum;
    sum = {1'b0, acc} + {1'b0, frac};
    return sum[FRAC_W];
  endfunction

  // Index of the final prescaled cycle of the current period.
  function automatic logic [LW-1:0] period_last(input logic [DIV_W-1:0] n,
                                                input logic stretch);
    return {1'b0, n} - LW'(1) + LW'(stretch);
  endfunction

  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [SUB_W-1:0]  sub;
  logic              tick_q, bit_q;

  wire              stretch    = frac_carry(acc, div_frac);
  wire [LW-1:0]     last       = period_last(div_int, stretch);
  wire              div_zero   = (div_int == '0);
  wire              period_end = pre_en && !div_zero && ({1'b0, cnt} >= last);
  wire [SUB_W-1:0]  osr_n      = osr_ticks(osr_sel);
  wire              sub_end    = (sub >= osr_n - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      sub    <= '0;
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
      if (restart) begin
        cnt <= '0;
        acc <= '0;
        sub <= '0;
      end else if (period_end) begin
        cnt    <= '0;
        acc    <= acc + div_frac;
        tick_q <= 1'b1;
        if (sub_end) begin
          sub   <= '0;
          bit_q <= 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end else if (pre_en && !div_zero) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign tick    = tick_q;
  assign bit_stb = bit_q;

  // R5: a zero divisor yields no tick
  p_zero_div_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_int) == '0) |-> !tick_q);
  // R2: a tick only follows a prescaled enable
  p_tick_after_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(pre_en));
  // R7: the restart edge never emits a tick
  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> !tick_q);
  // R8: bit strobes ride on ticks
  p_bit_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q |-> tick_q);
endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual #(
  parameter int DIV_W     = 16,
  parameter int FRAC_W    = 4,
  parameter int PRE_RATIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_div4,
  input  logic [1:0]        osr_sel,
  input  logic [DIV_W-1:0]  tx_div_int,
  input  logic [FRAC_W-1:0] tx_div_frac,
  input  logic              tx_div_wr,
  input  logic [DIV_W-1:0]  rx_div_int,
  input  logic [FRAC_W-1:0] rx_div_frac,
  input  logic              rx_div_wr,
  output logic              tx_tick,
  output logic              tx_bit,
  output logic              rx_tick,
  output logic              rx_bit
);
  localparam int NCH = 2;

  logic pre_en;
  logic [NCH-1:0][DIV_W-1:0]  div_i;
  logic [NCH-1:0][FRAC_W-1:0] div_f;
  logic [NCH-1:0]             wr, tk, bs;

  assign div_i = {rx_div_int, tx_div_int};
  assign div_f = {rx_div_frac, tx_div_frac};
  assign wr    = {rx_div_wr, tx_div_wr};

  baud_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel_div(pre_div4), .pre_en(pre_en)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      baud_chan #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .restart(wr[c]),
        .div_int(div_i[c]), .div_frac(div_f[c]), .osr_sel(osr_sel),
        .tick(tk[c]), .bit_stb(bs[c])
      );
    end
  endgenerate

  assign tx_tick = tk[0];
  assign rx_tick = tk[1];
  assign tx_bit  = bs[0];
  assign rx_bit  = bs[1];

  // R1: outputs idle in the cycle after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !(tx_tick || rx_tick || tx_bit || rx_bit));
endmodule

// File: tb/tb_baud_gen_dual.sv
module tb_baud_gen_dual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre_div4 = 1'b0;
  logic [1:0] osr_sel = 2'b00;
  logic [15:0] tx_div_int = 16'd0, rx_div_int = 16'd0;
  logic [3:0]  tx_div_frac = 4'd0, rx_div_frac = 4'd0;
  logic tx_div_wr = 1'b0, rx_div_wr = 1'b0;
  logic tx_tick, tx_bit, rx_tick, rx_bit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  baud_gen_dual dut (
    .clk(clk), .rst_n(rst_n), .pre_div4(pre_div4), .osr_sel(osr_sel),
    .tx_div_int(tx_div_int), .tx_div_frac(tx_div_frac), .tx_div_wr(tx_div_wr),
    .rx_div_int(rx_div_int), .rx_div_frac(rx_div_frac), .rx_div_wr(rx_div_wr),
    .tx_tick(tx_tick), .tx_bit(tx_bit), .rx_tick(rx_tick), .rx_bit(rx_bit)
  );

  // {pre, mode[1:0], frac[3:0], div[15:0]}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 2'b00, 4'd0,  16'd5},
    {1'b0, 2'b01, 4'd3,  16'd4},
    {1'b1, 2'b10, 4'd0,  16'd3},
    {1'b0, 2'b10, 4'd8,  16'd2},
    {1'b1, 2'b00, 4'd5,  16'd2},
    {1'b0, 2'b11, 4'd15, 16'd3},
    {1'b1, 2'b01, 4'd1,  16'd6},
    {1'b0, 2'b00, 4'd12, 16'd7}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int extra(input int k, input int f);
    return ((k + 1) * f) / 16 - (k * f) / 16;
  endfunction

  function automatic int per_bit(input int mode);
    if (mode == 1) return 8;
    if (mode == 2) return 4;
    return 16;
  endfunction

  function automatic logic tk_of(input bit ch);
    return ch ? rx_tick : tx_tick;
  endfunction

  function automatic logic bs_of(input bit ch);
    return ch ? rx_bit : tx_bit;
  endfunction

  task automatic pulse_wr(input bit ch);
    if (ch) rx_div_wr = 1'b1; else tx_div_wr = 1'b1;
    @(negedge clk);
    rx_div_wr = 1'b0;
    tx_div_wr = 1'b0;
  endtask

  // Restart one direction, then time 16 intervals after its first tick.
  task automatic measure(input bit ch, input int pre, input int mode,
                         input int n, input int f, input string tag);
    int bits;
    int bad;
    bits = 0;
    bad = 0;
    pulse_wr(ch);
    for (int w = 0; w < 5000; w++) begin
      if (tk_of(ch)) break;
      @(negedge clk);
    end
    for (int k = 1; k <= 16; k++) begin
      int len;
      int exp;
      len = 0;
      for (int w = 0; w < 5000; w++) begin
        @(negedge clk);
        len++;
        if (tk_of(ch)) break;
      end
      if (bs_of(ch)) bits++;
      exp = (pre ? 4 : 1) * (n + extra(k, f));
      if (len != exp) bad++;
      chk(tag, len, exp);
    end
    chk("R8 bit strobes", bits, 16 / per_bit(mode));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int any;
    // R1: outputs held low during reset
    any = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      any += int'(tx_tick) + int'(rx_tick) + int'(tx_bit) + int'(rx_bit);
    end
    chk("R1 reset outputs", any, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2, R3, R4, R8 on transmit; R9 on receive with other divisors
    for (int v = 0; v < 8; v++) begin
      int pre, mode, f, n;
      pre  = int'(VEC[v][22]);
      mode = int'(VEC[v][21:20]);
      f    = int'(VEC[v][19:16]);
      n    = int'(VEC[v][15:0]);
      pre_div4    = VEC[v][22];
      osr_sel     = VEC[v][21:20];
      tx_div_int  = 16'(n);
      tx_div_frac = 4'(f);
      rx_div_int  = 16'(n + 2);
      rx_div_frac = 4'(15 - f);
      measure(1'b0, pre, mode, n, f, f != 0 ? "R4 tx interval" :
              (pre != 0 ? "R2 tx interval" : "R3 tx interval"));
      measure(1'b1, pre, mode, n + 2, 15 - f, "R9 rx interval");
    end

    // R5: zero divisor, no ticks
    pre_div4 = 1'b0;
    tx_div_int = 16'd0;
    tx_div_frac = 4'd7;
    pulse_wr(1'b0);
    any = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      any += int'(tx_tick);
    end
    chk("R5 zero divisor ticks", any, 0);

    // R6: divide by one passes every cycle through
    tx_div_int = 16'd1;
    tx_div_frac = 4'd0;
    pulse_wr(1'b0);
    repeat (3) @(negedge clk);
    any = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      any += int'(tx_tick);
    end
    chk("R6 passthrough ticks", any, 20);

    // R7: restart taken on the edge of an expected tick
    tx_div_int = 16'd3;
    pulse_wr(1'b0);
    for (int w = 0; w < 100; w++) begin
      @(negedge clk);
      if (tx_tick) break;
    end
    @(negedge clk);
    @(negedge clk);
    tx_div_wr = 1'b1;
    @(negedge clk);
    tx_div_wr = 1'b0;
    chk("R7 tick on restart edge", int'(tx_tick), 0);
    @(negedge clk);
    chk("R7 first cycle after restart", int'(tx_tick), 0);
    @(negedge clk);
    chk("R7 second cycle after restart", int'(tx_tick), 0);
    @(negedge clk);
    chk("R7 tick after full period", int'(tx_tick), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule